// File: doc/BRIEF.md
# Repetitive-Operation Mode Sequencer

This block is the central mode controller of a hybrid analog/digital computer. It turns front-panel mode requests into one operating mode shared by the integrators (set-potentiometer, initial condition, operate or hold). In repetitive operation it alternates an initial-condition phase and an operate phase. The operate phase length is programmable and the initial-condition length depends on a fast-speed switch. The block reports the phase on two complementary flags and gives a short strobe when each operate phase ends.

External controls can stop and restart the phase timer, freeze it, or steer the central mode through a master pair of inputs. A force-hold input overrides every selection except set-potentiometer. An overload indication can be made sticky. Each integrator has a local pair of control inputs that can take it out of central control. All time is counted in ticks of a 1 MHz clock enable (`tick`).

Mode codes on `integ_mode` (two bits per integrator, integrator i at bits [2i+1:2i]): 00 operate, 01 hold, 10 initial condition, 11 set-potentiometer. Request bits on `mode_req`: bit 0 set-potentiometer, bit 1 hold, bit 2 initial condition, bit 3 operate, bit 4 repetitive.

Top module: `repop_sequencer`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, the selection is set-potentiometer: `phase_a`=1, `phase_b`=0, `eob`=0, `ovl_flag`=0, `st_pp`=`st_ic`=`st_op`=0, and every integrator reads code 11.
- R2: A clock edge with any request bit set takes the highest one in the order bit 0, bit 1, bit 2, bit 3, bit 4. With no bit set, the previous selection is kept.
- R3: The phase timer runs only while repetitive is selected and `run`=1. Each initial-condition phase lasts `IC_FAST` ticks if `fast` was 1 when the phase began, and `IC_SLOW` ticks if it was 0.
- R4: The operate phase lasts F×`BASE`×10^D ticks. F is `op_factor` clamped to 5..105 and D is `op_decade` (0..3). Both values are sampled when the preceding initial-condition phase began.
- R5: `phase_a`=1 in the initial-condition phase and `phase_b`=1 in the operate phase, and the two are always complementary.
- R6: `eob` rises on the tick that ends an operate phase and falls on the next tick, so it lasts one tick interval.
- R7: While the timer is not running (`run`=0 or repetitive not selected), it is held at the start of an initial-condition phase with `eob`=0.
- R8: While `tmr_hold`=1, ticks do not advance the timer. A tick that sees `tmr_hold` back at 0 during an operate phase ends that phase, as in R6.
- R9: With repetitive selected, the master pair is decoded as follows: `mst_h`=1 gives hold; otherwise `mst_ic`=1 follows the timer (initial condition in phase A, operate in phase B); `mst_ic`=0 gives operate. Outside repetitive the pair has no effect.
- R10: `orh`=1 makes the central mode hold under every selection except set-potentiometer.
- R11: `ovl_flag` is `ovl_in` registered. While `ovl_store`=1, a flag that has been set stays set.
- R12: An integrator's local pair (`loc_ic`,`loc_h`) gives 00 operate, 01 hold, 10 initial condition, and 11 the central mode. Set-potentiometer reaches every integrator regardless of its local pair.
- R13: `st_pp` is 1 while repetitive is selected; `st_ic` and `st_op` are 1 while the central mode is initial condition or operate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 1 MHz time-base enable |
| mode_req | input | 5 | Mode request bits (see encoding) |
| fast | input | 1 | Fast-speed switch, selects short initial-condition phase |
| run | input | 1 | Timer run; 0 holds the timer at its start |
| tmr_hold | input | 1 | Timer freeze; its release ends an operate phase |
| mst_ic | input | 1 | Master initial-condition input (default 1) |
| mst_h | input | 1 | Master hold input (default 0) |
| orh | input | 1 | Force hold, beaten only by set-potentiometer |
| ovl_in | input | 1 | Raw overload indication |
| ovl_store | input | 1 | Makes the overload flag sticky |
| op_factor | input | 7 | Operate-length factor, clamped to 5..105 |
| op_decade | input | 2 | Operate-length decade exponent |
| loc_ic | input | NI | Local initial-condition input per integrator |
| loc_h | input | NI | Local hold input per integrator |
| phase_a | output | 1 | Initial-condition phase flag |
| phase_b | output | 1 | Operate phase flag |
| eob | output | 1 | End-of-operate strobe |
| ovl_flag | output | 1 | Overload flag |
| st_pp | output | 1 | Repetitive selected |
| st_ic | output | 1 | Central mode is initial condition |
| st_op | output | 1 | Central mode is operate |
| integ_mode | output | 2*NI | Mode code per integrator |

## Verification
Two events can land on the same tick: the operate count running out and the release of `tmr_hold`. Either one alone ends the phase. The bench toggles `tmr_hold` at random through long runs of repetitive operation with short operate phases, so a release sometimes meets the last count. A cycle-accurate reference model in the bench sets how many `eob` pulses are expected, and when. Every cycle is compared, so a doubled strobe or an operate phase that runs on would be caught at once. The same comparison covers force-hold arriving in the cycle a set-potentiometer request is taken.

// File: rtl/repop_pkg.sv
package repop_pkg;

  typedef enum logic [1:0] {
    MD_OP   = 2'b00,
    MD_HOLD = 2'b01,
    MD_IC   = 2'b10,
    MD_SP   = 2'b11
  } md_t;

  typedef enum logic [2:0] {
    SEL_SP = 3'd0,
    SEL_HD = 3'd1,
    SEL_IC = 3'd2,
    SEL_OP = 3'd3,
    SEL_PP = 3'd4
  } sel_t;

  localparam int unsigned FACTOR_LO = 5;
  localparam int unsigned FACTOR_HI = 105;

  // Clamp the raw factor into its legal window.
  function automatic int unsigned clamp_factor(input logic [6:0] f);
    int unsigned v;
    v = {25'd0, f};
    if (v < FACTOR_LO) v = FACTOR_LO;
    if (v > FACTOR_HI) v = FACTOR_HI;
    return v;
  endfunction

  // Operate-phase length in ticks: factor * base * 10^decade.
  function automatic int unsigned op_ticks(input logic [6:0] f,
                                           input logic [1:0] d,
                                           input int unsigned base);
    int unsigned scale;
    scale = base;
    for (int i = 0; i < 3; i++) begin
      if (i < int'(d)) scale = scale * 10;
    end
    return clamp_factor(f) * scale;
  endfunction

  // Highest-priority request wins; none keeps the current selection.
  function automatic sel_t next_sel(input logic [4:0] req, input sel_t cur);
    if (req[0])      return SEL_SP;
    else if (req[1]) return SEL_HD;
    else if (req[2]) return SEL_IC;
    else if (req[3]) return SEL_OP;
    else if (req[4]) return SEL_PP;
    return cur;
  endfunction

  // Central mode from selection, master pair, timer phase and force-hold.
  function automatic md_t central_mode(input sel_t sel, input logic m_ic,
                                       input logic m_h, input logic ph_a,
                                       input logic force_hold);
    if (sel == SEL_SP) return MD_SP;
    if (force_hold)    return MD_HOLD;
    case (sel)
      SEL_HD:  return MD_HOLD;
      SEL_IC:  return MD_IC;
      SEL_OP:  return MD_OP;
      default: begin
        if (m_h)              return MD_HOLD;
        else if (m_ic && ph_a) return MD_IC;
        else                  return MD_OP;
      end
    endcase
  endfunction

  // Per-integrator override by the local pair.
  function automatic md_t local_mode(input logic l_ic, input logic l_h,
                                     input md_t c);
    if (c == MD_SP) return MD_SP;
    case ({l_ic, l_h})
      2'b00:   return MD_OP;
      2'b01:   return MD_HOLD;
      2'b10:   return MD_IC;
      default: return c;
    endcase
  endfunction

endpackage

// File: rtl/repop_mode_select.sv
module repop_mode_select
  import repop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] mode_req,
  input  logic       mst_ic,
  input  logic       mst_h,
  input  logic       orh,
  input  logic       phase_a,
  output sel_t       sel,
  output md_t        cmode
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel <= SEL_SP;
    else        sel <= next_sel(mode_req, sel);
  end

  always_comb cmode = central_mode(sel, mst_ic, mst_h, phase_a, orh);

endmodule

// File: rtl/repop_phase_timer.sv
module repop_phase_timer
  import repop_pkg::*;
#(
  parameter int unsigned CW      = 27,
  parameter int unsigned IC_SLOW = 700000,
  parameter int unsigned IC_FAST = 7000,
  parameter int unsigned BASE    = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       active,
  input  logic       fast,
  input  logic       tmr_hold,
  input  logic [6:0] op_factor,
  input  logic [1:0] op_decade,
  output logic       phase_a,
  output logic       eob,
  output logic       end_op,
  output logic       ic_done
);

  logic          in_op;
  logic          hold_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] ic_len;
  logic [CW-1:0] op_len;
  logic [CW-1:0] ic_len_new;
  logic [CW-1:0] op_len_new;
  logic          hold_fall;

  assign ic_len_new = fast ? CW'(IC_FAST) : CW'(IC_SLOW);
  assign op_len_new = CW'(op_ticks(op_factor, op_decade, BASE));
  assign hold_fall  = hold_q && !tmr_hold;

  assign end_op  = active && tick && in_op &&
                   (hold_fall || (!tmr_hold && cnt == op_len - 1'b1));
  assign ic_done = active && tick && !in_op && !tmr_hold &&
                   cnt == ic_len - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_op  <= 1'b0;
      hold_q <= 1'b0;
      eob    <= 1'b0;
      cnt    <= '0;
      ic_len <= CW'(IC_SLOW);
      op_len <= CW'(op_ticks(7'd5, 2'd0, BASE));
    end else if (!active) begin
      in_op  <= 1'b0;
      hold_q <= 1'b0;
      eob    <= 1'b0;
      cnt    <= '0;
      ic_len <= ic_len_new;
      op_len <= op_len_new;
    end else if (tick) begin
      hold_q <= tmr_hold;
      eob    <= end_op;
      if (end_op) begin
        in_op  <= 1'b0;
        cnt    <= '0;
        ic_len <= ic_len_new;
        op_len <= op_len_new;
      end else if (tmr_hold) begin
        cnt <= cnt;
      end else if (ic_done) begin
        in_op <= 1'b1;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign phase_a = !in_op;

endmodule

// File: rtl/repop_local_mux.sv
module repop_local_mux
  import repop_pkg::*;
#(
  parameter int unsigned NI = 6
) (
  input  md_t              cmode,
  input  logic [NI-1:0]    loc_ic,
  input  logic [NI-1:0]    loc_h,
  output logic [2*NI-1:0]  integ_mode
);

  for (genvar g = 0; g < NI; g++) begin : g_integ
    md_t m;
    always_comb m = local_mode(loc_ic[g], loc_h[g], cmode);
    assign integ_mode[2*g +: 2] = m;
  end

endmodule

// File: rtl/repop_sequencer.sv
module repop_sequencer
  import repop_pkg::*;
#(
  parameter int unsigned NI      = 6,
  parameter int unsigned IC_SLOW = 700000,
  parameter int unsigned IC_FAST = 7000,
  parameter int unsigned BASE    = 1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [4:0]      mode_req,
  input  logic            fast,
  input  logic            run,
  input  logic            tmr_hold,
  input  logic            mst_ic,
  input  logic            mst_h,
  input  logic            orh,
  input  logic            ovl_in,
  input  logic            ovl_store,
  input  logic [6:0]      op_factor,
  input  logic [1:0]      op_decade,
  input  logic [NI-1:0]   loc_ic,
  input  logic [NI-1:0]   loc_h,
  output logic            phase_a,
  output logic            phase_b,
  output logic            eob,
  output logic            ovl_flag,
  output logic            st_pp,
  output logic            st_ic,
  output logic            st_op,
  output logic [2*NI-1:0] integ_mode
);

  localparam int unsigned OP_MAX  = FACTOR_HI * BASE * 1000;
  localparam int unsigned LEN_MAX = (OP_MAX > IC_SLOW) ? OP_MAX : IC_SLOW;
  localparam int unsigned CW      = $clog2(LEN_MAX + 1);

  sel_t sel;
  md_t  cmode;
  logic timer_active;
  logic sel_sp_w;
  logic end_op_w;
  logic ic_done_w;

  assign timer_active = (sel == SEL_PP) && run;
  assign sel_sp_w     = (sel == SEL_SP);

  repop_mode_select u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_req (mode_req),
    .mst_ic   (mst_ic),
    .mst_h    (mst_h),
    .orh      (orh),
    .phase_a  (phase_a),
    .sel      (sel),
    .cmode    (cmode)
  );

  repop_phase_timer #(
    .CW      (CW),
    .IC_SLOW (IC_SLOW),
    .IC_FAST (IC_FAST),
    .BASE    (BASE)
  ) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .active    (timer_active),
    .fast      (fast),
    .tmr_hold  (tmr_hold),
    .op_factor (op_factor),
    .op_decade (op_decade),
    .phase_a   (phase_a),
    .eob       (eob),
    .end_op    (end_op_w),
    .ic_done   (ic_done_w)
  );

  repop_local_mux #(.NI(NI)) u_loc (
    .cmode      (cmode),
    .loc_ic     (loc_ic),
    .loc_h      (loc_h),
    .integ_mode (integ_mode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovl_flag <= 1'b0;
    else        ovl_flag <= ovl_in || (ovl_store && ovl_flag);
  end

  assign phase_b = !phase_a;
  assign st_pp   = (sel == SEL_PP);
  assign st_ic   = (cmode == MD_IC);
  assign st_op   = (cmode == MD_OP);

endmodule

// File: rtl/repop_sequencer_chk.sv
module repop_sequencer_chk #(
  parameter int unsigned NI = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [4:0]      mode_req,
  input logic            orh,
  input logic            ovl_in,
  input logic            ovl_flag,
  input logic            phase_a,
  input logic            phase_b,
  input logic            eob,
  input logic            sel_sp_w,
  input logic            timer_active,
  input logic            end_op_w,
  input logic [1:0]      cmode,
  input logic [2*NI-1:0] integ_mode
);

  // R5
  a_r5_flags_opposite: assert property (@(posedge clk) disable iff (!rst_n)
    phase_a != phase_b);

  // R6
  a_r6_strobe_after_op: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eob) |-> ($past(phase_b) && phase_a));

  // R6 R8
  a_r6_end_sets_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    end_op_w |=> eob);

  // R7
  a_r7_idle_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    !timer_active |=> (phase_a && !eob));

  // R10
  a_r10_force_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (orh && !sel_sp_w) |-> (cmode == 2'b01));

  // R11
  a_r11_overload_seen: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_in |=> ovl_flag);

  // R12
  a_r12_sp_everywhere: assert property (@(posedge clk) disable iff (!rst_n)
    sel_sp_w |-> (integ_mode == {NI{2'b11}}));

  // R2
  a_r2_sp_request_first: assert property (@(posedge clk) disable iff (!rst_n)
    mode_req[0] |=> sel_sp_w);

endmodule

bind repop_sequencer repop_sequencer_chk #(.NI(NI)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_req     (mode_req),
  .orh          (orh),
  .ovl_in       (ovl_in),
  .ovl_flag     (ovl_flag),
  .phase_a      (phase_a),
  .phase_b      (phase_b),
  .eob          (eob),
  .sel_sp_w     (sel_sp_w),
  .timer_active (timer_active),
  .end_op_w     (end_op_w),
  .cmode        (cmode),
  .integ_mode   (integ_mode)
);

// File: tb/repop_sequencer_test.sv
module repop_sequencer_test;

  localparam int NI   = 4;
  localparam int ICS  = 40;
  localparam int ICF  = 6;
  localparam int BSE  = 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            tick = 1'b0;
  logic [4:0]      mode_req = '0;
  logic            fast = 1'b0, run = 1'b0, tmr_hold = 1'b0;
  logic            mst_ic = 1'b1, mst_h = 1'b0, orh = 1'b0;
  logic            ovl_in = 1'b0, ovl_store = 1'b0;
  logic [6:0]      op_factor = 7'd5;
  logic [1:0]      op_decade = 2'd0;
  logic [NI-1:0]   loc_ic = '1, loc_h = '1;
  logic            phase_a, phase_b, eob, ovl_flag, st_pp, st_ic, st_op;
  logic [2*NI-1:0] integ_mode;

  repop_sequencer #(.NI(NI), .IC_SLOW(ICS), .IC_FAST(ICF), .BASE(BSE)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_req(mode_req), .fast(fast),
    .run(run), .tmr_hold(tmr_hold), .mst_ic(mst_ic), .mst_h(mst_h), .orh(orh),
    .ovl_in(ovl_in), .ovl_store(ovl_store), .op_factor(op_factor),
    .op_decade(op_decade), .loc_ic(loc_ic), .loc_h(loc_h), .phase_a(phase_a),
    .phase_b(phase_b), .eob(eob), .ovl_flag(ovl_flag), .st_pp(st_pp),
    .st_ic(st_ic), .st_op(st_op), .integ_mode(integ_mode));

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---- reference model (selection: 0 sp,1 hd,2 ic,3 op,4 pp) ----
  int m_sel, m_left, m_opl;
  bit m_op, m_eb, m_hq, m_ovl;

  function automatic int want_oplen(input int f, input int d);
    int lim, mult;
    lim  = (f < 5) ? 5 : ((f > 105) ? 105 : f);
    mult = (d == 0) ? 1 : (d == 1) ? 10 : (d == 2) ? 100 : 1000;
    return lim * mult * BSE;
  endfunction

  function automatic int want_central(input int s, input bit a);
    if (s == 0) return 3;
    if (orh) return 1;
    if (s == 1) return 1;
    if (s == 2) return 2;
    if (s == 3) return 0;
    if (mst_h) return 1;
    return (mst_ic && a) ? 2 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel <= 0; m_op <= 0; m_eb <= 0; m_hq <= 0; m_ovl <= 0;
      m_left <= ICS; m_opl <= want_oplen(5, 0);
    end else begin
      bit fin;
      m_ovl <= ovl_in | (ovl_store & m_ovl);
      if (mode_req[0]) m_sel <= 0;
      else if (mode_req[1]) m_sel <= 1;
      else if (mode_req[2]) m_sel <= 2;
      else if (mode_req[3]) m_sel <= 3;
      else if (mode_req[4]) m_sel <= 4;
      if (!(m_sel == 4 && run)) begin
        m_op <= 0; m_eb <= 0; m_hq <= 0;
        m_left <= fast ? ICF : ICS;
        m_opl <= want_oplen(op_factor, op_decade);
      end else if (tick) begin
        fin = m_op && !tmr_hold && (m_hq || m_left == 1);
        m_hq <= tmr_hold;
        m_eb <= fin;
        if (fin) begin
          m_op <= 0; m_left <= fast ? ICF : ICS;
          m_opl <= want_oplen(op_factor, op_decade);
        end else if (!tmr_hold) begin
          if (m_left == 1) begin m_op <= 1; m_left <= m_opl; end
          else m_left <= m_left - 1;
        end
      end
    end
  end

  task automatic compare_all();
    int cm, li;
    cm = want_central(m_sel, !m_op);
    chk("R3 R4 R5 R7 R8 phase_a", phase_a, !m_op);
    chk("R5 phase_b", phase_b, m_op);
    chk("R6 R8 eob", eob, m_eb);
    chk("R11 ovl_flag", ovl_flag, m_ovl);
    chk("R2 R13 st_pp", st_pp, m_sel == 4);
    chk("R9 R10 R13 st_ic", st_ic, cm == 2);
    chk("R9 R10 R13 st_op", st_op, cm == 0);
    for (int i = 0; i < NI; i++) begin
      if (cm == 3) li = 3;
      else case ({loc_ic[i], loc_h[i]})
        2'b00: li = 0;
        2'b01: li = 1;
        2'b10: li = 2;
        default: li = cm;
      endcase
      chk("R12 integ_mode", integ_mode[2*i +: 2], li);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic pulse_req(input logic [4:0] r);
    @(negedge clk); compare_all();
    mode_req = r;
    @(negedge clk); compare_all();
    mode_req = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(1500000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired, actual running expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20241));
    // R1: reset state
    #22;
    chk("R1 phase_a", phase_a, 1); chk("R1 phase_b", phase_b, 0);
    chk("R1 eob", eob, 0); chk("R1 ovl_flag", ovl_flag, 0);
    chk("R1 st_pp", st_pp, 0); chk("R1 integ_mode", integ_mode, {NI{2'b11}});
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", integ_mode, {NI{2'b11}});
    compare_all();

    // Directed: fast repetitive run, shortest operate phase, tick every cycle
    tick = 1; fast = 1; run = 1; op_factor = 7'd5;
    pulse_req(5'b10000);
    step(60);
    // Release hold on the last operate count
    op_factor = 7'd3;  // clamps to 5 (R4)
    step(40);
    while (!phase_b) step(1);
    step(4);
    tmr_hold = 1; step(3); tmr_hold = 0; step(20);
    // All requests together: set-potentiometer wins (R2), force-hold same cycle
    orh = 1; pulse_req(5'b11111); step(3);
    chk("R2 R10 sp beats orh", integ_mode, {NI{2'b11}});
    pulse_req(5'b10010); step(3);   // hold wins over repetitive
    chk("R2 hold selected", st_pp, 0);
    orh = 0; pulse_req(5'b10000);
    fast = 0; run = 0; step(3); run = 1; step(200);

    // Constrained random
    for (int c = 0; c < 60000; c++) begin
      @(negedge clk);
      compare_all();
      tick = ($urandom % 3) != 0;
      mode_req = '0;
      if ($urandom % 400 == 0) mode_req = 5'b10000;
      else if ($urandom % 1500 == 0) mode_req = 5'(1 << ($urandom % 5));
      else if ($urandom % 3000 == 0) mode_req = 5'($urandom);
      if ($urandom % 3000 == 0) run = ~run;
      if ($urandom % 500 == 0) tmr_hold = ~tmr_hold;
      if ($urandom % 900 == 0) orh = ~orh;
      if ($urandom % 2000 == 0) fast = ~fast;
      if ($urandom % 1000 == 0) begin mst_ic = $urandom; mst_h = $urandom; end
      if ($urandom % 1200 == 0) begin loc_ic = NI'($urandom); loc_h = NI'($urandom); end
      if ($urandom % 40 == 0) ovl_in = ~ovl_in;
      if ($urandom % 400 == 0) ovl_store = ~ovl_store;
      if ($urandom % 300 == 0) begin
        op_decade = 2'($urandom % 3);
        op_factor = (op_decade == 2) ? 7'(5 + $urandom % 6) : 7'($urandom);
      end
    end
    finish_run();
  end

endmodule